// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block is the processor-side engine that carries out an interrupt dispatch and the matching return. On an entry request it captures an 8-bit interrupt number together with the running instruction pointer, code selector, flags word and stack pointer. It checks that the 8-byte gate for that number lies inside a programmable descriptor table, and reads the gate as two 32-bit words. It then saves the interrupted state on a descending stack and hands back the handler's selector and offset, along with a flags word that has interrupts and single-stepping switched off.

A return request does the inverse. It pulls the saved instruction pointer, selector and flags off the stack, lowest address first, and reports them together with the restored stack pointer. All table and stack traffic uses one word-wide memory port that answers a read in the cycle after it is issued. A gate that falls outside the table limit sends the block into a halted state. Only reset leaves that state.

Top module: `irq_gate_seq`

## Requirements
- R1: The 48-bit table register is loaded from `tbl_wdata` when `tbl_load` is high. It carries the base in bits 47:16 and the limit in bytes in bits 15:0. `tbl_rdata` shows the loaded value from the next cycle and holds it while `tbl_load` is low.
- R2: An entry for vector v reads the gate's low word at base + 8·v and then its high word at base + 8·v + 4, in consecutive cycles.
- R3: When 8·v + 7 exceeds the limit, the block raises `shutdown` two cycles after accepting the request. It does not touch memory, ignores all requests and never signals `done` until reset. When 8·v + 7 equals the limit, the block dispatches normally.
- R4: Entry writes the original flags to sp−4, then the selector zero-extended to 32 bits to sp−8, then the instruction pointer to sp−12, in three consecutive cycles. The reported stack pointer is sp−12.
- R5: The entry result has its selector from low-word bits 31:16 and its offset from {high-word bits 31:16, low-word bits 15:0}. Its flags equal the input flags with bit 9 (interrupt enable) and bit 8 (trap) cleared.
- R6: Return reads the instruction pointer at sp, the selector from bits 15:0 of the word at sp+4, and the flags at sp+8, in that order. The reported stack pointer is sp+12.
- R7: `busy` is high from the cycle after an accepted request through the `done` cycle, and low afterwards. Requests that arrive while busy are ignored.
- R8: `done` is a single-cycle pulse. It comes 7 cycles after the accepting edge for an entry and 5 cycles after it for a return. Results stay valid until the next request.
- R9: If entry and return are requested in the same idle cycle, the entry is performed.
- R10: After reset the block is idle, with `busy`, `done` and `shutdown` low and the table register zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tbl_load | input | 1 | Load the table register |
| tbl_wdata | input | 48 | New table register value {base, limit} |
| tbl_rdata | output | 48 | Current table register value |
| ent_req | input | 1 | Start an interrupt entry |
| ent_vec | input | 8 | Interrupt number |
| cur_eip | input | 32 | Instruction pointer to save |
| cur_cs | input | 16 | Code selector to save |
| cur_flags | input | 32 | Flags word to save |
| sp_in | input | 32 | Stack pointer at the request |
| ret_req | input | 1 | Start an interrupt return |
| mem_req | output | 1 | Memory access strobe |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read |
| res_eip | output | 32 | Resulting instruction pointer |
| res_cs | output | 16 | Resulting code selector |
| res_flags | output | 32 | Resulting flags word |
| res_sp | output | 32 | Resulting stack pointer |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence complete, results valid |
| shutdown | output | 1 | Halted on a table limit violation |

## Verification
The assertions rely on the memory port answering every read in exactly the following cycle. They also rely on `tbl_load` not being used while a sequence is running, since the limit check reads the live register. The stimulus loads the table only while the block is idle. It keeps the table and stack regions of its word-addressed memory model apart, so a push never overwrites a gate. The bench does not compute a pop's expected values until the words it will read are final.

// File: rtl/irqseq_pkg.sv
package irqseq_pkg;

    localparam int ADDR_W     = 32;
    localparam int WORD_W     = 32;
    localparam int VEC_W      = 8;
    localparam int LIM_W      = 16;
    localparam int SEL_W      = 16;
    localparam int SLOT_B     = WORD_W / 8;
    localparam int GATE_SHIFT = 3;
    localparam int FRAME_B    = 3 * SLOT_B;
    localparam int IF_BIT     = 9;
    localparam int TF_BIT     = 8;
    localparam int TBL_W      = ADDR_W + LIM_W;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [WORD_W-1:0] word_t;
    typedef logic [VEC_W-1:0]  vec_t;
    typedef logic [LIM_W-1:0]  lim_t;
    typedef logic [SEL_W-1:0]  sel_t;

    typedef struct packed {
        addr_t base;
        lim_t  limit;
    } tbl_t;

    typedef enum logic [3:0] {
        S_IDLE, S_CHK, S_GLO, S_GHI, S_PFL, S_PCS, S_PIP,
        S_POP0, S_POP1, S_POP2, S_POP3, S_FIN, S_HALT
    } seq_st_e;

    typedef struct packed {
        word_t eip;
        sel_t  cs;
        word_t flags;
        addr_t sp;
    } frame_t;

    function automatic sel_t gate_sel(word_t lo);
        return lo[31:16];
    endfunction

    function automatic word_t gate_off(word_t lo, word_t hi);
        return {hi[31:16], lo[15:0]};
    endfunction

    function automatic word_t mask_entry(word_t f);
        word_t r;
        r = f;
        r[IF_BIT] = 1'b0;
        r[TF_BIT] = 1'b0;
        return r;
    endfunction

    function automatic addr_t gate_addr(addr_t base, vec_t v, logic upper);
        addr_t a;
        a = base + (addr_t'(v) << GATE_SHIFT);
        if (upper) a = a + addr_t'(SLOT_B);
        return a;
    endfunction

endpackage

// File: rtl/irq_tbl_reg.sv
module irq_tbl_reg
    import irqseq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  tbl_t wdata,
    output tbl_t q
);

    always_ff @(posedge clk) begin
        if (rst)       q <= '0;
        else if (load) q <= wdata;
    end

    AST_TBL_HOLD: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(q)); // R1

endmodule

// File: rtl/irq_limit_chk.sv
module irq_limit_chk
    import irqseq_pkg::*;
(
    input  vec_t vec,
    input  lim_t limit,
    output logic over
);

    localparam int CMP_W = LIM_W + 1;

    logic [CMP_W-1:0] last_byte;

    always_comb begin
        last_byte = CMP_W'({vec, {GATE_SHIFT{1'b1}}});
        over      = last_byte > {1'b0, limit};
    end

endmodule

// File: rtl/irq_seq_fsm.sv
module irq_seq_fsm
    import irqseq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   ent_req,
    input  vec_t   ent_vec,
    input  word_t  cur_eip,
    input  sel_t   cur_cs,
    input  word_t  cur_flags,
    input  addr_t  sp_in,
    input  logic   ret_req,
    input  addr_t  tbl_base,
    input  logic   over,
    output vec_t   vec_q,
    output logic   mem_req,
    output logic   mem_we,
    output addr_t  mem_addr,
    output word_t  mem_wdata,
    input  word_t  mem_rdata,
    output frame_t res,
    output logic   busy,
    output logic   done,
    output logic   shutdown
);

    seq_st_e st;
    addr_t   sp_q;
    word_t   eip_q;
    sel_t    cs_q;
    word_t   fl_q;
    word_t   lo_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= S_IDLE;
            vec_q <= '0;
            sp_q  <= '0;
            eip_q <= '0;
            cs_q  <= '0;
            fl_q  <= '0;
            lo_q  <= '0;
            res   <= '0;
        end else begin
            case (st)
                S_IDLE: begin
                    if (ent_req) begin
                        vec_q <= ent_vec;
                        sp_q  <= sp_in;
                        eip_q <= cur_eip;
                        cs_q  <= cur_cs;
                        fl_q  <= cur_flags;
                        st    <= S_CHK;
                    end else if (ret_req) begin
                        sp_q <= sp_in;
                        st   <= S_POP0;
                    end
                end
                S_CHK:  st <= over ? S_HALT : S_GLO;
                S_GLO:  st <= S_GHI;
                S_GHI: begin
                    lo_q <= mem_rdata;
                    st   <= S_PFL;
                end
                S_PFL: begin
                    res.eip <= gate_off(lo_q, mem_rdata);
                    res.cs  <= gate_sel(lo_q);
                    st      <= S_PCS;
                end
                S_PCS:  st <= S_PIP;
                S_PIP: begin
                    res.flags <= mask_entry(fl_q);
                    res.sp    <= sp_q - addr_t'(FRAME_B);
                    st        <= S_FIN;
                end
                S_POP0: st <= S_POP1;
                S_POP1: begin
                    res.eip <= mem_rdata;
                    st      <= S_POP2;
                end
                S_POP2: begin
                    res.cs <= mem_rdata[SEL_W-1:0];
                    st     <= S_POP3;
                end
                S_POP3: begin
                    res.flags <= mem_rdata;
                    res.sp    <= sp_q + addr_t'(FRAME_B);
                    st        <= S_FIN;
                end
                S_FIN:  st <= S_IDLE;
                S_HALT: st <= S_HALT;
                default: st <= S_HALT;
            endcase
        end
    end

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        case (st)
            S_GLO: begin
                mem_req  = 1'b1;
                mem_addr = gate_addr(tbl_base, vec_q, 1'b0);
            end
            S_GHI: begin
                mem_req  = 1'b1;
                mem_addr = gate_addr(tbl_base, vec_q, 1'b1);
            end
            S_PFL: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = sp_q - addr_t'(SLOT_B);
                mem_wdata = fl_q;
            end
            S_PCS: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = sp_q - addr_t'(2 * SLOT_B);
                mem_wdata = word_t'(cs_q);
            end
            S_PIP: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = sp_q - addr_t'(FRAME_B);
                mem_wdata = eip_q;
            end
            S_POP0: begin
                mem_req  = 1'b1;
                mem_addr = sp_q;
            end
            S_POP1: begin
                mem_req  = 1'b1;
                mem_addr = sp_q + addr_t'(SLOT_B);
            end
            S_POP2: begin
                mem_req  = 1'b1;
                mem_addr = sp_q + addr_t'(2 * SLOT_B);
            end
            default: ;
        endcase
    end

    assign busy     = (st != S_IDLE) && (st != S_HALT);
    assign done     = (st == S_FIN);
    assign shutdown = (st == S_HALT);

    AST_SHUT_STICKY: assert property (@(posedge clk) disable iff (rst)
        shutdown |=> shutdown); // R3
    AST_SHUT_QUIET: assert property (@(posedge clk) disable iff (rst)
        shutdown |-> (!mem_req && !done)); // R3
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R8
    AST_DONE_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |-> busy); // R7
    AST_PUSH_DESC: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we && $past(mem_req && mem_we))
        |-> (mem_addr == $past(mem_addr) - addr_t'(SLOT_B))); // R4
    AST_READ_ASC: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we && $past(mem_req && !mem_we))
        |-> (mem_addr == $past(mem_addr) + addr_t'(SLOT_B))); // R6

endmodule

// File: rtl/irq_gate_seq.sv
module irq_gate_seq
    import irqseq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        tbl_load,
    input  logic [47:0] tbl_wdata,
    output logic [47:0] tbl_rdata,
    input  logic        ent_req,
    input  logic [7:0]  ent_vec,
    input  logic [31:0] cur_eip,
    input  logic [15:0] cur_cs,
    input  logic [31:0] cur_flags,
    input  logic [31:0] sp_in,
    input  logic        ret_req,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic [31:0] mem_rdata,
    output logic [31:0] res_eip,
    output logic [15:0] res_cs,
    output logic [31:0] res_flags,
    output logic [31:0] res_sp,
    output logic        busy,
    output logic        done,
    output logic        shutdown
);

    tbl_t   tbl_q;
    vec_t   vec_q;
    logic   over;
    frame_t res;

    irq_tbl_reg u_tbl (
        .clk   (clk),
        .rst   (rst),
        .load  (tbl_load),
        .wdata (tbl_t'(tbl_wdata)),
        .q     (tbl_q)
    );

    irq_limit_chk u_lim (
        .vec   (vec_q),
        .limit (tbl_q.limit),
        .over  (over)
    );

    irq_seq_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .ent_req   (ent_req),
        .ent_vec   (ent_vec),
        .cur_eip   (cur_eip),
        .cur_cs    (cur_cs),
        .cur_flags (cur_flags),
        .sp_in     (sp_in),
        .ret_req   (ret_req),
        .tbl_base  (tbl_q.base),
        .over      (over),
        .vec_q     (vec_q),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .res       (res),
        .busy      (busy),
        .done      (done),
        .shutdown  (shutdown)
    );

    assign tbl_rdata = tbl_q;
    assign res_eip   = res.eip;
    assign res_cs    = res.cs;
    assign res_flags = res.flags;
    assign res_sp    = res.sp;

endmodule

// File: tb/irq_gate_seq_tb.sv
module irq_gate_seq_tb;

    typedef struct {
        logic        we;
        logic [31:0] addr;
        logic [31:0] data;
    } op_t;

    typedef struct {
        logic [31:0] eip;
        logic [15:0] cs;
        logic [31:0] flags;
        logic [31:0] sp;
    } res_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tbl_load = 1'b0;
    logic [47:0] tbl_wdata = '0;
    logic [47:0] tbl_rdata;
    logic        ent_req = 1'b0;
    logic [7:0]  ent_vec = '0;
    logic [31:0] cur_eip = '0;
    logic [15:0] cur_cs = '0;
    logic [31:0] cur_flags = '0;
    logic [31:0] sp_in = '0;
    logic        ret_req = 1'b0;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic [31:0] res_eip, res_flags, res_sp;
    logic [15:0] res_cs;
    logic        busy, done, shutdown;

    logic [31:0] mem_arr [0:1023];
    logic [31:0] tbl_base_m;
    op_t         exp_ops[$];
    res_t        exp_res[$];
    op_t         op_m;
    res_t        res_m;
    int          n_checks = 0;
    int          n_err = 0;

    always #5 clk = ~clk;

    irq_gate_seq u_dut (
        .clk(clk), .rst(rst), .tbl_load(tbl_load), .tbl_wdata(tbl_wdata),
        .tbl_rdata(tbl_rdata), .ent_req(ent_req), .ent_vec(ent_vec),
        .cur_eip(cur_eip), .cur_cs(cur_cs), .cur_flags(cur_flags),
        .sp_in(sp_in), .ret_req(ret_req), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .res_eip(res_eip), .res_cs(res_cs), .res_flags(res_flags),
        .res_sp(res_sp), .busy(busy), .done(done), .shutdown(shutdown)
    );

    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) mem_arr[mem_addr[11:2]] <= mem_wdata;
            else        mem_rdata <= mem_arr[mem_addr[11:2]];
        end
    end

    task automatic chk(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Monitor: compares memory traffic and results against the scoreboard
    always @(negedge clk) begin
        if (!rst) begin
            if (mem_req) begin
                if (exp_ops.size() == 0) begin
                    chk(1'b0, "R3/R7 unexpected memory access", {mem_addr, mem_wdata}, 64'h0);
                end else begin
                    op_m = exp_ops.pop_front();
                    chk(mem_we == op_m.we && mem_addr == op_m.addr &&
                        (!op_m.we || mem_wdata == op_m.data),
                        "R2/R4/R6 memory access order",
                        {mem_addr, mem_wdata}, {op_m.addr, op_m.data});
                end
            end
            if (done) begin
                if (exp_res.size() == 0) begin
                    chk(1'b0, "R7 unexpected done", 64'h1, 64'h0);
                end else begin
                    res_m = exp_res.pop_front();
                    chk(res_eip == res_m.eip, "R5/R6 result eip", res_eip, res_m.eip);
                    chk(res_cs == res_m.cs, "R5/R6 result cs", res_cs, res_m.cs);
                    chk(res_flags == res_m.flags, "R5/R6 result flags", res_flags, res_m.flags);
                    chk(res_sp == res_m.sp, "R4/R6 result sp", res_sp, res_m.sp);
                end
            end
        end
    end

    task automatic load_tbl(input logic [31:0] base, input logic [15:0] lim);
        @(negedge clk);
        tbl_load  = 1'b1;
        tbl_wdata = {base, lim};
        tbl_base_m = base;
        @(negedge clk);
        tbl_load  = 1'b0;
        tbl_wdata = 48'h5A5A_5A5A_5A5A;
        chk(tbl_rdata == {base, lim}, "R1 table readback", tbl_rdata, {base, lim});
        @(negedge clk);
        chk(tbl_rdata == {base, lim}, "R1 table hold", tbl_rdata, {base, lim});
    endtask

    task automatic put_gate(input logic [7:0] v);
        logic [31:0] ga;
        ga = tbl_base_m + {21'h0, v, 3'b000};
        mem_arr[ga[11:2]]       = {16'h0008 + {8'h0, v}, 16'h1000 + {4'h0, v, 4'h0}};
        mem_arr[ga[11:2] + 10'd1] = {16'hC000 + {8'h0, v}, 16'h8E00};
    endtask

    task automatic run_entry(input logic [7:0] v, input logic [31:0] e,
                             input logic [15:0] c, input logic [31:0] f,
                             input logic [31:0] sp, input bit both, input bit poke);
        logic [31:0] ga, lo, hi;
        int cnt;
        ga = tbl_base_m + {21'h0, v, 3'b000};
        lo = mem_arr[ga[11:2]];
        hi = mem_arr[ga[11:2] + 10'd1];
        exp_ops.push_back('{1'b0, ga, 32'h0});
        exp_ops.push_back('{1'b0, ga + 32'd4, 32'h0});
        exp_ops.push_back('{1'b1, sp - 32'd4, f});
        exp_ops.push_back('{1'b1, sp - 32'd8, {16'h0, c}});
        exp_ops.push_back('{1'b1, sp - 32'd12, e});
        exp_res.push_back('{{hi[31:16], lo[15:0]}, lo[31:16], f & ~32'h0000_0300, sp - 32'd12});
        @(negedge clk);
        ent_req = 1'b1; ret_req = both; ent_vec = v;
        cur_eip = e; cur_cs = c; cur_flags = f; sp_in = sp;
        @(negedge clk);
        ent_req = 1'b0; ret_req = 1'b0;
        cnt = 1;
        while (!done && cnt < 40) begin
            chk(busy, "R7 busy during entry", {63'h0, busy}, 64'h1);
            ent_req = poke && (cnt == 2);
            ret_req = poke && (cnt == 4);
            @(negedge clk);
            cnt++;
        end
        ent_req = 1'b0; ret_req = 1'b0;
        chk(cnt == 7, "R8 entry latency", cnt, 7);
        @(negedge clk);
        chk(!done, "R8 done single cycle", {63'h0, done}, 64'h0);
        chk(!busy, "R7 busy drops after done", {63'h0, busy}, 64'h0);
    endtask

    task automatic run_return(input logic [31:0] sp);
        int cnt;
        exp_ops.push_back('{1'b0, sp, 32'h0});
        exp_ops.push_back('{1'b0, sp + 32'd4, 32'h0});
        exp_ops.push_back('{1'b0, sp + 32'd8, 32'h0});
        exp_res.push_back('{mem_arr[sp[11:2]], mem_arr[sp[11:2] + 10'd1][15:0],
                            mem_arr[sp[11:2] + 10'd2], sp + 32'd12});
        @(negedge clk);
        ret_req = 1'b1; sp_in = sp;
        @(negedge clk);
        ret_req = 1'b0;
        cnt = 1;
        while (!done && cnt < 40) begin
            chk(busy, "R7 busy during return", {63'h0, busy}, 64'h1);
            @(negedge clk);
            cnt++;
        end
        chk(cnt == 5, "R8 return latency", cnt, 5);
        @(negedge clk);
        chk(!done, "R8 done single cycle", {63'h0, done}, 64'h0);
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) mem_arr[i] = 32'h0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        chk(!busy && !done && !shutdown, "R10 idle after reset",
            {61'h0, busy, done, shutdown}, 64'h0);
        chk(tbl_rdata == 48'h0, "R10 table cleared", tbl_rdata, 64'h0);

        load_tbl(32'h0000_0100, 16'h003F);
        for (int v = 0; v < 8; v++) put_gate(v[7:0]);

        // R4 R5 basic entry with IF and TF set
        run_entry(8'd3, 32'h0040_1234, 16'h0023, 32'h0000_0346, 32'h0000_0F00, 1'b0, 1'b0);
        // R6 return restores the saved frame
        run_return(32'h0000_0EF4);
        // R6 only low half of the selector slot is used
        mem_arr[(32'h0EF8) >> 2] = 32'hABCD_0023;
        run_return(32'h0000_0EF4);
        // R3 last in-range gate, R7 requests while busy ignored
        run_entry(8'd7, 32'h1111_2222, 16'h0033, 32'h0000_0002, 32'h0000_0E00, 1'b0, 1'b1);
        // R9 simultaneous requests take the entry path
        run_entry(8'd0, 32'hDEAD_BEE0, 16'hFFFF, 32'hFFFF_FFFF, 32'h0000_0D00, 1'b1, 1'b0);

        // R3 largest vector with the largest limit
        load_tbl(32'h0000_0100, 16'hFFFF);
        put_gate(8'd255);
        run_entry(8'd255, 32'h0000_0010, 16'h0010, 32'h0000_0100, 32'h0000_0C00, 1'b0, 1'b0);

        // R3 one byte short of the last gate: shutdown
        load_tbl(32'h0000_0100, 16'h003E);
        @(negedge clk);
        ent_req = 1'b1; ent_vec = 8'd7; sp_in = 32'h0000_0B00;
        @(negedge clk);
        ent_req = 1'b0;
        @(negedge clk);
        chk(shutdown, "R3 shutdown on limit violation", {63'h0, shutdown}, 64'h1);
        chk(!busy, "R3 not busy in shutdown", {63'h0, busy}, 64'h0);
        for (int k = 0; k < 10; k++) begin
            ent_req = (k == 2); ret_req = (k == 5); ent_vec = 8'd1;
            @(negedge clk);
        end
        ent_req = 1'b0; ret_req = 1'b0;
        chk(shutdown && !done, "R3 shutdown persists", {62'h0, shutdown, done}, 64'h2);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!shutdown && !busy, "R10 reset leaves shutdown", {62'h0, shutdown, busy}, 64'h0);
        chk(tbl_rdata == 48'h0, "R10 table cleared again", tbl_rdata, 64'h0);

        chk(exp_ops.size() == 0, "R2/R4/R6 all accesses seen", exp_ops.size(), 0);
        chk(exp_res.size() == 0, "R8 all results seen", exp_res.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule